// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a processor whose datapath spends several clock cycles on each instruction and shares one ALU and one memory between those steps. A Moore state machine steps through fetch, decode, execute, memory and write-back phases. Each instruction visits only the phases it needs. Every control output is a function of the current state alone, so the datapath sees steady strobes for the whole cycle.

The sequencer reads the 6-bit opcode field of the instruction register and an overflow flag from the ALU. Five instruction kinds are supported: load word, store word, register-to-register ALU operations, branch-if-equal and jump. An opcode outside that set, or an overflow during a register ALU operation, sends the machine into one of two exception states. Those states record the cause, save the return address and redirect the program counter to the handler entry point. The fetch that follows starts the handler.

Top module: `mcyc_ctrl`

## Requirements
- R1: A low `rst_n` at a rising clock edge puts the sequencer in the fetch step, whatever step it was in.
- R2: The fetch step drives pc_wr=1, mem_rd=1, ir_wr=1, addr_from_alu=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. The next step is always decode.
- R3: The decode step drives alu_a_sel=0, alu_b_sel=11 and alu_op=00. It then dispatches on the opcode: 0x23 (load) and 0x2B (store) go to address calculation, 0x00 to register execute, 0x04 to branch and 0x02 to jump.
- R4: A load passes through fetch, decode, address calculation, memory read and write-back (5 cycles). Address calculation drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. Memory read drives mem_rd=1 and addr_from_alu=1. Write-back drives rf_wr=1, wb_from_mem=1 and rf_dst_rd=0.
- R5: A store passes through fetch, decode, address calculation and memory write (4 cycles). Memory write drives mem_wr=1 and addr_from_alu=1.
- R6: A register ALU operation without overflow passes through fetch, decode, execute and register completion (4 cycles). Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Completion drives rf_wr=1, rf_dst_rd=1 and wb_from_mem=0.
- R7: If alu_ovf is high during the execute step, the next step is the overflow exception state instead of register completion. rf_wr then stays 0 for the whole instruction.
- R8: A branch passes through fetch, decode and branch completion (3 cycles). Branch completion drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01.
- R9: A jump passes through fetch, decode and jump completion (3 cycles). Jump completion drives pc_wr=1 and pc_src=10.
- R10: Any opcode other than the five listed sends decode to the undefined-instruction exception state. The overflow exception state has the same outputs except cause_code=1, and the undefined-instruction state drives cause_code=0. Both exception states drive cause_wr=1, epc_wr=1, pc_wr=1, pc_src=11, alu_a_sel=0, alu_b_sel=01 and alu_op=01, and both go back to fetch.
- R11: In every step, each control output not named for that step is 0. mem_rd and mem_wr are never high together.
- R12: alu_ovf has no effect in any step other than execute. A load or branch with alu_ovf held high follows its normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | Signed overflow flag from the ALU |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write gated by the ALU zero flag |
| addr_from_alu | output | 1 | Memory address taken from the ALU result register instead of the PC |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data taken from the memory data register |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler entry |
| alu_op | output | 2 | ALU mode: 00 add, 01 subtract, 10 function-field decode |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination register from the rd field (1) or the rt field (0) |
| cause_code | output | 1 | Exception cause value: 0 undefined opcode, 1 overflow |
| cause_wr | output | 1 | Cause register load |
| epc_wr | output | 1 | Exception PC register load |

## Verification
The state register is the only register between the inputs and the outputs. The outputs of a step therefore appear one rising edge after the step is entered, and they hold for that whole cycle. Stimulus changes on the falling edge and is held for the whole instruction. After each rising edge, the bench compares the complete control word at the next falling edge with a word it builds from the requirements, one step per cycle. It also counts the edges until the fetch word reappears, and checks that count against the cycle count the requirement gives. The decode dispatch and the overflow decision each show up in the word one edge after the step that samples them. The reset check looks at the word one edge after rst_n is sampled low.

// File: rtl/mcyc_ctrl_pkg.sv
// Package: shared types for the multi-cycle control sequencer.
// Holds the step encoding, the opcode constants and the control word layout.
package mcyc_ctrl_pkg;

    localparam int OP_W    = 6;
    localparam int STATE_W = 4;

    localparam logic [OP_W-1:0] OPC_REG    = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'h02;

    typedef enum logic [STATE_W-1:0] {
        S_FETCH     = 4'd0,
        S_DECODE    = 4'd1,
        S_ADDR      = 4'd2,
        S_MEM_RD    = 4'd3,
        S_LOAD_WB   = 4'd4,
        S_MEM_WR    = 4'd5,
        S_EXEC      = 4'd6,
        S_REG_DONE  = 4'd7,
        S_BRANCH    = 4'd8,
        S_JUMP      = 4'd9,
        S_EXC_UNDEF = 4'd10,
        S_EXC_OVF   = 4'd11
    } step_t;

    typedef enum logic [2:0] {
        K_REG, K_LOAD, K_STORE, K_BRANCH, K_JUMP, K_UNDEF
    } op_kind_t;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_from_mem;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_wr;
        logic       rf_dst_rd;
        logic       cause_code;
        logic       cause_wr;
        logic       epc_wr;
    } ctl_word_t;

endpackage

// File: rtl/mcyc_next_step.sv
// Module: next-step logic of the sequencer.
// Classifies the opcode and picks the following step from the current one.
// Assumes the opcode is stable during decode and alu_ovf is valid during execute.
module mcyc_next_step
    import mcyc_ctrl_pkg::*;
#(
    parameter int              W_OP    = OP_W,
    parameter logic [W_OP-1:0] C_REG   = OPC_REG,
    parameter logic [W_OP-1:0] C_LOAD  = OPC_LOAD,
    parameter logic [W_OP-1:0] C_STORE = OPC_STORE,
    parameter logic [W_OP-1:0] C_BRNCH = OPC_BRANCH,
    parameter logic [W_OP-1:0] C_JUMP  = OPC_JUMP
) (
    input  step_t           cur,
    input  logic [W_OP-1:0] opcode,
    input  logic            alu_ovf,
    output step_t           nxt
);

    op_kind_t kind;

    // Map the opcode onto an instruction kind.
    always_comb begin
        if      (opcode == C_REG)   kind = K_REG;
        else if (opcode == C_LOAD)  kind = K_LOAD;
        else if (opcode == C_STORE) kind = K_STORE;
        else if (opcode == C_BRNCH) kind = K_BRANCH;
        else if (opcode == C_JUMP)  kind = K_JUMP;
        else                        kind = K_UNDEF;
    end

    // Choose the next step from the current step, the kind and the overflow flag.
    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (kind)
                    K_LOAD, K_STORE: nxt = S_ADDR;
                    K_REG:           nxt = S_EXEC;
                    K_BRANCH:        nxt = S_BRANCH;
                    K_JUMP:          nxt = S_JUMP;
                    default:         nxt = S_EXC_UNDEF;
                endcase
            end
            S_ADDR:   nxt = (kind == K_LOAD) ? S_MEM_RD : S_MEM_WR;
            S_MEM_RD: nxt = S_LOAD_WB;
            S_EXEC:   nxt = alu_ovf ? S_EXC_OVF : S_REG_DONE;
            default:  nxt = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mcyc_ctl_decode.sv
// Module: Moore output decode of the sequencer.
// Turns the current step into the full control word; every field that a
// step does not name stays zero.
module mcyc_ctl_decode
    import mcyc_ctrl_pkg::*;
(
    input  step_t     cur,
    output ctl_word_t cw
);

    // Build the control word for the current step, starting from all zero.
    always_comb begin
        cw = '0;
        unique case (cur)
            S_FETCH: begin
                cw.mem_rd    = 1'b1;
                cw.ir_wr     = 1'b1;
                cw.alu_b_sel = 2'b01;
                cw.pc_wr     = 1'b1;
            end
            S_DECODE:  cw.alu_b_sel = 2'b11;
            S_ADDR: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = 2'b10;
            end
            S_MEM_RD: begin
                cw.mem_rd        = 1'b1;
                cw.addr_from_alu = 1'b1;
            end
            S_LOAD_WB: begin
                cw.rf_wr       = 1'b1;
                cw.wb_from_mem = 1'b1;
            end
            S_MEM_WR: begin
                cw.mem_wr        = 1'b1;
                cw.addr_from_alu = 1'b1;
            end
            S_EXEC: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_op    = 2'b10;
            end
            S_REG_DONE: begin
                cw.rf_wr     = 1'b1;
                cw.rf_dst_rd = 1'b1;
            end
            S_BRANCH: begin
                cw.alu_a_sel  = 1'b1;
                cw.alu_op     = 2'b01;
                cw.pc_wr_cond = 1'b1;
                cw.pc_src     = 2'b01;
            end
            S_JUMP: begin
                cw.pc_wr  = 1'b1;
                cw.pc_src = 2'b10;
            end
            S_EXC_UNDEF, S_EXC_OVF: begin
                cw.cause_code = (cur == S_EXC_OVF);
                cw.cause_wr   = 1'b1;
                cw.epc_wr     = 1'b1;
                cw.alu_b_sel  = 2'b01;
                cw.alu_op     = 2'b01;
                cw.pc_wr      = 1'b1;
                cw.pc_src     = 2'b11;
            end
            default: cw = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
// Module: top of the multi-cycle control sequencer.
// Holds the step register (synchronous active-low reset to fetch), joins the
// next-step and output-decode logic, and spreads the control word onto ports.
// Assumes opcode comes from the instruction register and is held after fetch.
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
#(
    parameter int W_OP = OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W_OP-1:0] opcode,
    input  logic            alu_ovf,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            addr_from_alu,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            wb_from_mem,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_op,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            rf_wr,
    output logic            rf_dst_rd,
    output logic            cause_code,
    output logic            cause_wr,
    output logic            epc_wr
);

    step_t     step_q;
    step_t     step_d;
    ctl_word_t cw;

    mcyc_next_step #(.W_OP(W_OP)) u_next (
        .cur     (step_q),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (step_d)
    );

    mcyc_ctl_decode u_dec (
        .cur (step_q),
        .cw  (cw)
    );

    // Step register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= S_FETCH;
        else        step_q <= step_d;
    end

    // Spread the control word onto the output ports.
    always_comb begin
        pc_wr         = cw.pc_wr;
        pc_wr_cond    = cw.pc_wr_cond;
        addr_from_alu = cw.addr_from_alu;
        mem_rd        = cw.mem_rd;
        mem_wr        = cw.mem_wr;
        ir_wr         = cw.ir_wr;
        wb_from_mem   = cw.wb_from_mem;
        pc_src        = cw.pc_src;
        alu_op        = cw.alu_op;
        alu_a_sel     = cw.alu_a_sel;
        alu_b_sel     = cw.alu_b_sel;
        rf_wr         = cw.rf_wr;
        rf_dst_rd     = cw.rf_dst_rd;
        cause_code    = cw.cause_code;
        cause_wr      = cw.cause_wr;
        epc_wr        = cw.epc_wr;
    end

    logic op_known;
    assign op_known = (opcode == OPC_REG) || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE) || (opcode == OPC_BRANCH) ||
                      (opcode == OPC_JUMP);

    // Reset forces fetch on the next cycle.
    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> (ir_wr && mem_rd && pc_wr));

    // Fetch is always followed by decode.
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == S_FETCH) |=> (step_q == S_DECODE));

    // A load memory read is followed by a write-back from memory.
    assert_load_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_from_alu) |=> (rf_wr && wb_from_mem && !rf_dst_rd));

    // Overflow in execute leads to the overflow exception, with no register write.
    assert_no_overflow_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == S_EXEC && alu_ovf) |=> (cause_wr && cause_code && !rf_wr));

    // An unknown opcode at decode leads to the undefined-instruction exception.
    assert_undef_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == S_DECODE && !op_known) |=> (cause_wr && !cause_code && epc_wr));

    // Both exception states go back to fetch.
    assert_exc_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ir_wr);

    // Memory read and write are never requested together.
    assert_mem_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

endmodule

// File: tb/mcyc_ctrl_bench.sv
// Bench for mcyc_ctrl: a vector table of instructions with expected step
// sequences, then directed reset checks.
module mcyc_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_ovf = 1'b0;
    logic       pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr, wb_from_mem;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, rf_wr, rf_dst_rd, cause_code, cause_wr, epc_wr;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_ctrl u_mcyc_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_from_alu(addr_from_alu),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mem(wb_from_mem),
        .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .cause_code(cause_code),
        .cause_wr(cause_wr), .epc_wr(epc_wr)
    );

    // Observed control word, field order fixed by the bench.
    logic [18:0] obs;
    assign obs = {pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr, wb_from_mem,
                  pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd,
                  cause_code, cause_wr, epc_wr};

    // Expected control word for each step number, taken from the requirements.
    function automatic logic [18:0] exp_word(input int s);
        logic pw = 0, pwc = 0, iod = 0, mr = 0, mw = 0, irw = 0, m2r = 0;
        logic [1:0] ps = 0, aop = 0, bs = 0;
        logic as = 0, rw = 0, rd = 0, cc = 0, cw = 0, ew = 0;
        case (s)
            0:  begin pw = 1; mr = 1; irw = 1; bs = 2'b01; end
            1:  bs = 2'b11;
            2:  begin as = 1; bs = 2'b10; end
            3:  begin mr = 1; iod = 1; end
            4:  begin rw = 1; m2r = 1; end
            5:  begin mw = 1; iod = 1; end
            6:  begin as = 1; aop = 2'b10; end
            7:  begin rw = 1; rd = 1; end
            8:  begin as = 1; aop = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin
                cc = (s == 11); cw = 1; ew = 1; bs = 2'b01; aop = 2'b01;
                pw = 1; ps = 2'b11;
            end
            default: ;
        endcase
        return {pw, pwc, iod, mr, mw, irw, m2r, ps, aop, as, bs, rw, rd, cc, cw, ew};
    endfunction

    task automatic check(input string req, input logic [18:0] exp);
        tests++;
        if (obs !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, obs, exp);
        end
    endtask

    // Vector: {opcode, ovf, length, step sequence (first step in low nibble)}
    typedef struct packed {
        logic [5:0]  op;
        logic        ovf;
        logic [2:0]  len;
        logic [19:0] seq;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{6'h23, 1'b0, 3'd5, 20'h43210, 4'd4},   // R4 load
        '{6'h2B, 1'b0, 3'd4, 20'h05210, 4'd5},   // R5 store
        '{6'h00, 1'b0, 3'd4, 20'h07610, 4'd6},   // R6 register op
        '{6'h00, 1'b1, 3'd4, 20'h0B610, 4'd7},   // R7 register op with overflow
        '{6'h04, 1'b0, 3'd3, 20'h00810, 4'd8},   // R8 branch
        '{6'h02, 1'b0, 3'd3, 20'h00910, 4'd9},   // R9 jump
        '{6'h3F, 1'b0, 3'd3, 20'h00A10, 4'd10},  // R10 undefined opcode
        '{6'h01, 1'b0, 3'd3, 20'h00A10, 4'd10},  // R10 undefined opcode
        '{6'h23, 1'b1, 3'd5, 20'h43210, 4'd12},  // R12 load with overflow high
        '{6'h04, 1'b1, 3'd3, 20'h00810, 4'd12}   // R12 branch with overflow high
    };

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state", exp_word(0));
        // Walk the vector table; each step is checked one edge after entry (R11 via full word).
        for (int v = 0; v < NVEC; v++) begin
            opcode  = VECS[v].op;
            alu_ovf = VECS[v].ovf;
            for (int k = 0; k < int'(VECS[v].len); k++) begin
                check($sformatf("R%0d step %0d (R2 R3 R11)", VECS[v].req, k),
                      exp_word(int'(VECS[v].seq[k*4 +: 4])));
                @(posedge clk);
                @(negedge clk);
            end
            check($sformatf("R%0d return to fetch after %0d cycles", VECS[v].req,
                  VECS[v].len), exp_word(0));
        end
        // Directed: reset in the middle of a load (R1).
        opcode = 6'h23;
        alu_ovf = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R4 address step before reset", exp_word(2));
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset mid-instruction", exp_word(0));
        // Reset held: stays in fetch (R1).
        @(posedge clk); @(negedge clk);
        check("R1 reset held", exp_word(0));
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 decode after reset release", exp_word(1));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule